// File: doc/BRIEF.md
# Video Display Output FIFO with Underrun Handling

This block is the output FIFO of one video display channel. A DMA engine fills it in bursts. The read side is drained by one word on every pixel-enable strobe during an active display line. An external timing generator supplies the frame-start, active-line and pixel-enable strobes. The block issues one DMA request each time enough space has opened up for a burst of `thr_i` words.

When the FIFO runs dry during an active line, the read side does not stall. The read pointer keeps moving, and whatever older word sits in that slot is driven out. If the late burst then arrives, it lands in the slots that belong to it. Correct pixels return as soon as the writes pull ahead of the reads again. Each underrun sets a sticky status bit, which can also raise an interrupt. If a request stays unserviced for a whole threshold's worth of pixels, the request chain is declared lost and requests stop.

Software recovers by raising the block-display input. That empties the FIFO, drops incoming writes, holds off requests and replaces the pixel output with a programmable fill value, while the video timing keeps running. Requests start again only at the first frame start seen after block-display is released. The same rule applies after reset.

Top module: `disp_out_fifo`

## Requirements
- R1: After reset, `pix_o` is 0 and `dma_req_o`, `irq_o`, `und_o` and `lost_o` are 0. No request is raised before the first `frame_start_i` strobe.
- R2: `dma_req_o` pulses for one cycle when all of these hold: requests are enabled, none is outstanding, and free space (DEPTH minus occupancy) is at least `thr_i`. The request stays outstanding until `thr_i` accepted writes retire it.
- R3: A read happens in a cycle with `line_act_i` and `pix_en_i` both high. The word read appears on `pix_o` one cycle later. Words come out in the order they were written.
- R4: A read while occupancy is zero or below, and block-display is low, sets the sticky `und_o` bit. A read with data present does not set it.
- R5: `irq_o` is high only while `und_o` and `und_ie_i` are both high.
- R6: An underrun does not stall the read side. Each read advances the pointer and outputs the stale slot content. After late writes overtake the read pointer, freshly written words come out again.
- R7: While `blk_i` is high, the FIFO is emptied, writes are discarded and `dma_req_o` stays 0.
- R8: In the cycle after any cycle with `blk_i` high, `pix_o` carries `dflt_i`.
- R9: After `blk_i` falls, requests stay off until a `frame_start_i` strobe arrives with `blk_i` low.
- R10: The chain is lost on the `thr_i`-th read during an outstanding request, unless that same cycle's write retires the request. A lost chain sets the sticky `lost_o` bit and blocks further requests until `blk_i` is raised.
- R11: A one-cycle pulse on `clr_und_i` or `clr_lost_i` clears its status bit. An event in the same cycle as the clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Frame-start strobe from timing generator |
| line_act_i | input | 1 | High during active display line |
| pix_en_i | input | 1 | Pixel-enable strobe |
| wr_en_i | input | 1 | DMA write strobe |
| wr_data_i | input | DW | DMA write data |
| thr_i | input | log2(DEPTH) | Request threshold in words, 1 to DEPTH-1 |
| blk_i | input | 1 | Block-display control |
| dflt_i | input | DW | Fill value output while blocked |
| und_ie_i | input | 1 | Underrun interrupt enable |
| clr_und_i | input | 1 | Write-one clear of underrun status |
| clr_lost_i | input | 1 | Write-one clear of lost-chain status |
| pix_o | output | DW | Pixel data |
| dma_req_o | output | 1 | DMA request pulse |
| irq_o | output | 1 | Underrun interrupt |
| und_o | output | 1 | Sticky underrun status |
| lost_o | output | 1 | Sticky lost-chain status |

## Verification
A status clear and a new underrun can fall in the same cycle. The bench provokes this by pulsing `clr_und_i` in the same cycle as a read from an empty FIFO, and the bit must still read 1 afterwards. A clear pulse alone, with no read, must take the bit to 0. On the request side, the final write of a burst and the threshold-th pending read can also coincide. The lost-chain test keeps the two apart and checks that a burst retired one read early leaves `lost_o` low.

// File: rtl/dfo_pkg.sv
package dfo_pkg;
  localparam int ST_UND  = 0;
  localparam int ST_LOST = 1;
  localparam int N_ST    = 2;

  // signed occupancy needs headroom for lag below zero
  function automatic int occ_width(input int aw);
    return aw + 2;
  endfunction
endpackage

// File: rtl/dfo_sticky.sv
module dfo_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= set_i | (q_o & ~clr_i);
endmodule

// File: rtl/dfo_store.sv
module dfo_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int OCC_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    wr_i,
  input  logic [DW-1:0]           wr_data_i,
  input  logic                    rd_i,
  input  logic [DW-1:0]           dflt_i,
  output logic [DW-1:0]           pix_o,
  output logic signed [OCC_W-1:0] occ_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic signed [OCC_W-1:0] OCC_MIN = {1'b1, {(OCC_W-1){1'b0}}};

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          wr_ok, rd_ok;

  assign wr_ok = wr_i & ~flush_i;
  assign rd_ok = rd_i & ~flush_i;

  always_ff @(posedge clk_i)
    if (wr_ok) mem_q[wp_q] <= wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_o <= '0;
      pix_o <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_o <= '0;
      pix_o <= dflt_i;
    end else begin
      if (wr_ok) wp_q <= wp_q + 1'b1;
      // read side never stalls, even past the write pointer
      if (rd_ok) begin
        rp_q  <= rp_q + 1'b1;
        pix_o <= mem_q[rp_q];
      end
      case ({wr_ok, rd_ok})
        2'b10:   occ_o <= occ_o + 1'b1;
        2'b01:   if (occ_o != OCC_MIN) occ_o <= occ_o - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dfo_dma.sv
module dfo_dma #(
  parameter int DEPTH = 16,
  parameter int OCC_W = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          frame_start_i,
  input  logic                          blk_i,
  input  logic                          wr_i,
  input  logic                          rd_i,
  input  logic [$clog2(DEPTH)-1:0]      thr_i,
  input  logic signed [OCC_W-1:0]       occ_i,
  output logic                          req_o,
  output logic                          lost_ev_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] ONE = 1;

  logic              en_q, halt_q, pend, wr_done;
  logic [AW-1:0]     credit_q, lag_q;
  logic signed [OCC_W:0] free;

  assign free    = (OCC_W+1)'(DEPTH) - {occ_i[OCC_W-1], occ_i};
  assign pend    = credit_q != '0;
  assign wr_done = wr_i & (credit_q == ONE);
  assign req_o   = en_q & ~halt_q & ~pend & ~blk_i & (thr_i != '0)
                 & (free >= $signed({3'b000, thr_i}));
  assign lost_ev_o = pend & rd_i & ~blk_i & (lag_q == thr_i - 1'b1) & ~wr_done;

  // frame gate: off on block, back on at next frame start
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            en_q <= 1'b0;
    else if (blk_i)         en_q <= 1'b0;
    else if (frame_start_i) en_q <= 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        halt_q <= 1'b0;
    else if (blk_i)     halt_q <= 1'b0;
    else if (lost_ev_o) halt_q <= 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q <= '0;
      lag_q    <= '0;
    end else if (blk_i) begin
      credit_q <= '0;
      lag_q    <= '0;
    end else if (req_o) begin
      credit_q <= thr_i;
      lag_q    <= '0;
    end else if (lost_ev_o) begin
      credit_q <= '0;
      lag_q    <= '0;
    end else if (pend) begin
      if (wr_i) credit_q <= credit_q - 1'b1;
      if (rd_i) lag_q    <= lag_q + 1'b1;
    end
  end
endmodule

// File: rtl/disp_out_fifo.sv
module disp_out_fifo
  import dfo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frame_start_i,
  input  logic                     line_act_i,
  input  logic                     pix_en_i,
  input  logic                     wr_en_i,
  input  logic [DW-1:0]            wr_data_i,
  input  logic [$clog2(DEPTH)-1:0] thr_i,
  input  logic                     blk_i,
  input  logic [DW-1:0]            dflt_i,
  input  logic                     und_ie_i,
  input  logic                     clr_und_i,
  input  logic                     clr_lost_i,
  output logic [DW-1:0]            pix_o,
  output logic                     dma_req_o,
  output logic                     irq_o,
  output logic                     und_o,
  output logic                     lost_o
);
  localparam int OCC_W = occ_width($clog2(DEPTH));

  logic                    rd, wr_acc, lost_ev;
  logic signed [OCC_W-1:0] occ;
  logic [N_ST-1:0]         st_set, st_clr, st_q;

  assign rd     = line_act_i & pix_en_i;
  assign wr_acc = wr_en_i & ~blk_i;

  dfo_store #(.DW(DW), .DEPTH(DEPTH), .OCC_W(OCC_W)) u_store (
    .clk_i, .rst_ni,
    .flush_i  (blk_i),
    .wr_i     (wr_en_i),
    .wr_data_i,
    .rd_i     (rd),
    .dflt_i,
    .pix_o,
    .occ_o    (occ)
  );

  dfo_dma #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_dma (
    .clk_i, .rst_ni,
    .frame_start_i,
    .blk_i,
    .wr_i      (wr_acc),
    .rd_i      (rd),
    .thr_i,
    .occ_i     (occ),
    .req_o     (dma_req_o),
    .lost_ev_o (lost_ev)
  );

  assign st_set[ST_UND]  = rd & ~blk_i & (occ <= 0);
  assign st_set[ST_LOST] = lost_ev;
  assign st_clr[ST_UND]  = clr_und_i;
  assign st_clr[ST_LOST] = clr_lost_i;

  for (genvar i = 0; i < N_ST; i++) begin : g_st
    dfo_sticky u_st (
      .clk_i, .rst_ni,
      .set_i (st_set[i]),
      .clr_i (st_clr[i]),
      .q_o   (st_q[i])
    );
  end

  assign und_o  = st_q[ST_UND];
  assign lost_o = st_q[ST_LOST];
  assign irq_o  = und_o & und_ie_i;
endmodule

// File: rtl/disp_out_fifo_chk.sv
module disp_out_fifo_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_start_i,
  input logic          blk_i,
  input logic [DW-1:0] dflt_i,
  input logic          clr_und_i,
  input logic          clr_lost_i,
  input logic [DW-1:0] pix_o,
  input logic          dma_req_o,
  input logic          und_o,
  input logic          lost_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            armed_q <= 1'b0;
    else if (blk_i)         armed_q <= 1'b0;
    else if (frame_start_i) armed_q <= 1'b1;

  // R2
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |=> !dma_req_o);

  // R7
  blk_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_i |-> !dma_req_o);

  // R8
  blk_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_i |=> pix_o == $past(dflt_i));

  // R9
  frame_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> !dma_req_o);

  // R4
  und_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    und_o && !clr_und_i |=> und_o);

  // R10
  lost_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o && !clr_lost_i |=> lost_o);
endmodule

bind disp_out_fifo disp_out_fifo_chk #(.DW(DW)) u_chk (
  .clk_i, .rst_ni, .frame_start_i, .blk_i, .dflt_i,
  .clr_und_i, .clr_lost_i, .pix_o, .dma_req_o, .und_o, .lost_o
);

// File: tb/disp_out_fifo_tb_top.sv
`timescale 1ns/1ps
module disp_out_fifo_tb_top;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_start_i = 1'b0, line_act_i = 1'b0, pix_en_i = 1'b0, wr_en_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [AW-1:0] thr_i = AW'(4);
  logic blk_i = 1'b0;
  logic [DW-1:0] dflt_i = 16'hDEAD;
  logic und_ie_i = 1'b0, clr_und_i = 1'b0, clr_lost_i = 1'b0;
  logic [DW-1:0] pix_o;
  logic dma_req_o, irq_o, und_o, lost_o;

  always #10 clk_i = ~clk_i;

  disp_out_fifo #(.DW(DW), .DEPTH(DEPTH)) dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] tb_mem [DEPTH];
  int m_rp = 0, m_wp = 0;
  logic [DW-1:0] exp_q [$];
  string tag_q [$];
  logic rd_seen = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // driver: one cycle of stimulus, expected pixel queued on a read
  task automatic cyc(input bit wr, input logic [DW-1:0] d, input bit rd, input string tag);
    wr_en_i = wr; wr_data_i = d; line_act_i = rd; pix_en_i = rd;
    if (rd) begin
      exp_q.push_back(blk_i ? dflt_i : tb_mem[m_rp % DEPTH]);
      tag_q.push_back(tag);
      if (!blk_i) m_rp++;
    end
    if (wr && !blk_i) begin
      tb_mem[m_wp % DEPTH] = d;
      m_wp++;
    end
    @(negedge clk_i);
    wr_en_i = 1'b0; line_act_i = 1'b0; pix_en_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk_i);
  endtask

  task automatic frame();
    frame_start_i = 1'b1;
    @(negedge clk_i);
    frame_start_i = 1'b0;
  endtask

  // monitor
  always @(posedge clk_i) rd_seen <= line_act_i & pix_en_i;
  always @(negedge clk_i) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 act=%0h exp=none", pix_o);
      end else chk(tag_q.pop_front(), pix_o, exp_q.pop_front());
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 pix", pix_o, 0);
    chk("R1 req", dma_req_o, 0);
    chk("R1 und", und_o, 0);
    chk("R1 lost", lost_o, 0);
    chk("R1 irq", irq_o, 0);
    idle();
    chk("R1 no req before frame", dma_req_o, 0);

    frame();
    chk("R2 req after frame", dma_req_o, 1);
    idle();
    chk("R2 req held off while pending", dma_req_o, 0);
    for (int i = 0; i < 4; i++) cyc(1, 16'h0100 + 16'(i), 0, "R3");
    chk("R2 req after burst", dma_req_o, 1);
    idle();
    for (int i = 4; i < 8; i++) cyc(1, 16'h0100 + 16'(i), 0, "R3");
    idle();
    for (int i = 8; i < 12; i++) cyc(1, 16'h0100 + 16'(i), 0, "R3");
    idle();
    for (int i = 12; i < 16; i++) cyc(1, 16'h0100 + 16'(i), 0, "R3");
    chk("R2 no req when full", dma_req_o, 0);

    for (int i = 0; i < 4; i++) cyc(0, '0, 1, "R3 order");
    chk("R2 req at threshold", dma_req_o, 1);
    idle();
    for (int i = 0; i < 3; i++) cyc(0, '0, 1, "R3 order");
    for (int i = 0; i < 4; i++) cyc(1, 16'h0110 + 16'(i), 0, "R3");
    chk("R10 serviced in time", lost_o, 0);
    chk("R2 below threshold", dma_req_o, 0);
    chk("R4 no false underrun", und_o, 0);

    // R10 lost chain
    cyc(0, '0, 1, "R3 order");
    chk("R2 req again", dma_req_o, 1);
    idle();
    for (int i = 0; i < 4; i++) cyc(0, '0, 1, "R10 data");
    chk("R10 lost set", lost_o, 1);
    chk("R10 requests halted", dma_req_o, 0);
    idle();
    chk("R10 still halted", dma_req_o, 0);
    clr_lost_i = 1'b1; idle(); clr_lost_i = 1'b0;
    chk("R11 lost cleared", lost_o, 0);
    chk("R10 halt survives clear", dma_req_o, 0);

    // R7 R8 block display
    blk_i = 1'b1; m_rp = 0; m_wp = 0;
    idle();
    chk("R8 default out", pix_o, 32'hDEAD);
    chk("R7 no req blocked", dma_req_o, 0);
    cyc(1, 16'h0BAD, 1, "R8 blocked read");
    cyc(1, 16'h0BAD, 1, "R8 blocked read");
    chk("R7 no req blocked", dma_req_o, 0);
    blk_i = 1'b0;
    idle();
    chk("R9 no req same frame", dma_req_o, 0);
    idle();
    chk("R9 no req same frame", dma_req_o, 0);
    frame();
    chk("R9 req after frame", dma_req_o, 1);
    idle();
    cyc(0, '0, 1, "R6 stale");
    chk("R7 writes discarded, underrun", und_o, 1);
    chk("R5 irq masked", irq_o, 0);
    und_ie_i = 1'b1; #1;
    chk("R5 irq enabled", irq_o, 1);

    // R6 catch-up
    cyc(1, 16'h0200, 1, "R6 stale");
    cyc(1, 16'h0201, 0, "R6");
    cyc(1, 16'h0202, 0, "R6");
    cyc(1, 16'h0203, 0, "R6");
    cyc(0, '0, 1, "R6 fresh");
    chk("R6 fresh data", pix_o, 32'h0202);

    // R11 clear vs event
    clr_und_i = 1'b1; idle(); clr_und_i = 1'b0;
    chk("R11 und cleared", und_o, 0);
    chk("R5 irq follows clear", irq_o, 0);
    cyc(0, '0, 1, "R3 order");
    chk("R4 read with data", und_o, 0);
    clr_und_i = 1'b1;
    cyc(0, '0, 1, "R6 stale");
    clr_und_i = 1'b0;
    chk("R11 event beats clear", und_o, 1);

    idle(); idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule